// File: doc/BRIEF.md
# Shared Subtractor Comparison ALU

This block is a parameterised, purely combinational add/subtract unit with a comparison layer on top. Two operands of independent widths are widened to the result width, by sign extension in signed mode and by zero extension otherwise. They then pass through a single ripple carry chain that takes a carry-in and a B-invert control. The unit returns the sum, the per-bit propagate vector (operand A XOR the possibly inverted B) and the carry out of every bit position.

When the unit subtracts (B-invert and carry-in both high), the comparison layer derives less-than, greater-than, equal and not-equal from that one subtraction's carries, propagate vector and sign bit. No separate comparator is built. A four-bit select chooses which of these relations are OR-combined into the comparison output, so one select code yields less-or-equal or greater-or-equal. The 1-bit result is zero-extended to the output width. For a plain addition the B-invert control is held at 0, and the carry-in is tied to 0 when it is not needed.

Top module: `shared_sub_alu`

## Requirements
- R1: `y` equals the extended A plus (B-invert ? NOT extended B : extended B) plus `ci`, modulo 2^Y_W.
- R2: `x[i]` equals bit i of extended A XOR (bit i of extended B XOR `bi`).
- R3: `co[i]` is the carry out of bit position i of the sum in R1, for every i from 0 to Y_W-1.
- R4: With `signed_mode`=1 each operand is sign-extended to Y_W bits; with `signed_mode`=0 it is zero-extended.
- R5: With `bi`=1, `ci`=1 and `signed_mode`=0, less-than is the inverse of `co[Y_W-1]` and matches the unsigned comparison A < B.
- R6: With `bi`=1, `ci`=1 and `signed_mode`=1, less-than is (`co[Y_W-1]` XOR `co[Y_W-2]`) XOR `y[Y_W-1]` and matches the signed comparison A < B.
- R7: Equal is the AND of all bits of `x`, and not-equal is its inverse, so equal holds exactly when A equals B under subtraction.
- R8: Greater-than is the inverse of (less-than OR equal); under subtraction exactly one of less-than, greater-than and equal is high.
- R9: `cmp_out` is the OR of the relations whose `cmp_sel` bit is set (bit 0 less-than, bit 1 greater-than, bit 2 equal, bit 3 not-equal), placed in bit 0 with every upper bit 0. Select 0000 gives 0, 0101 gives less-or-equal, and 0110 gives greater-or-equal.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | A_W | Operand A |
| b | input | B_W | Operand B |
| ci | input | 1 | Carry into bit 0 |
| bi | input | 1 | Invert B before the carry chain |
| signed_mode | input | 1 | 1: sign-extend operands and compare signed |
| cmp_sel | input | 4 | Relation select: bit0 lt, bit1 gt, bit2 eq, bit3 ne |
| y | output | Y_W | Sum |
| x | output | Y_W | Per-bit propagate vector |
| co | output | Y_W | Carry out of every bit position |
| cmp_out | output | CMP_W | OR of the selected relations, zero-extended |

## Verification
The relational assertions assume the unit is subtracting (B-invert and carry-in both 1) and are guarded by that condition. The arithmetic assertion assumes Y_W is at least the wider operand width and at least 2, so that the top two carries exist. The bench uses A_W=4, B_W=3, Y_W=4, which keeps within those widths while still exercising extension of B and signed overflow. It sweeps every operand pair in both modes, with all four carry-in and invert settings, and checks the comparison output under every select code only when subtracting.

// File: rtl/alu_pkg.sv
// Package: shared types for the shared-subtractor ALU.
// Assumes: nothing beyond IEEE 1800-2017 packed structs.
package alu_pkg;

    localparam int REL_SEL_W = 4;

    // Relation select; bit 0 is less-than, bit 3 is not-equal.
    typedef struct packed {
        logic ne;
        logic eq;
        logic gt;
        logic lt;
    } rel_sel_t;

endpackage

// File: rtl/opnd_extend.sv
// Module: widens one operand to the datapath width, filling with the
// sign bit when signed mode is on and with zeros otherwise.
// Assumes: OUT_W >= IN_W >= 1.
module opnd_extend #(
    parameter int IN_W  = 8,
    parameter int OUT_W = 8
) (
    input  logic [IN_W-1:0]  opnd,
    input  logic             signed_mode,
    output logic [OUT_W-1:0] opnd_ext,
    output logic             opnd_neg
);
    // Purpose: fill bit is the operand sign only in signed mode.
    always_comb opnd_neg = signed_mode & opnd[IN_W-1];

    // Purpose: copy the low bits and pad the rest with the fill bit.
    for (genvar g = 0; g < OUT_W; g++) begin : g_bit
        if (g < IN_W) begin : g_copy
            assign opnd_ext[g] = opnd[g];
        end else begin : g_pad
            assign opnd_ext[g] = opnd_neg;
        end
    end
endmodule

// File: rtl/ripple_addsub.sv
// Module: ripple carry adder with optional B inversion. Exposes sum,
// per-bit propagate and the carry out of every bit.
// Assumes: W >= 1; operands already widened to W bits.
module ripple_addsub #(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         ci,
    input  logic         bi,
    output logic [W-1:0] y,
    output logic [W-1:0] x,
    output logic [W-1:0] co
);
    logic [W-1:0] b_eff;
    logic [W-1:0] cin;

    // Purpose: conditionally invert B for subtraction.
    always_comb b_eff = b ^ {W{bi}};

    // Purpose: one full-adder slice per bit, carry rippling upward.
    for (genvar g = 0; g < W; g++) begin : g_slice
        if (g == 0) begin : g_first
            assign cin[g] = ci;
        end else begin : g_rest
            assign cin[g] = co[g-1];
        end
        assign x[g]  = a[g] ^ b_eff[g];
        assign y[g]  = x[g] ^ cin[g];
        assign co[g] = (a[g] & b_eff[g]) | (x[g] & cin[g]);
    end

    // Purpose: the slice chain must agree with a wide arithmetic sum.
    always_comb begin
        AST_SUM_ARITH: assert ({co[W-1], y} ==
                               ({1'b0, a} + {1'b0, b_eff} + (W+1)'(ci)))
            else $error("ripple sum mismatch"); // R1
    end
endmodule

// File: rtl/rel_decode.sv
// Module: turns the carry chain of one subtraction into less-than,
// greater-than, equal and not-equal, then ORs the selected ones.
// Assumes: the relations are meaningful only while subtracting
// (B inverted, carry-in 1); W >= 2.
module rel_decode
    import alu_pkg::*;
#(
    parameter int W     = 8,
    parameter int CMP_W = 1
) (
    input  logic [W-1:0]     x,
    input  logic [1:0]       co_top,
    input  logic             y_msb,
    input  logic             signed_mode,
    input  logic             sub_mode,
    input  rel_sel_t         sel,
    output logic [CMP_W-1:0] cmp_out,
    output logic             lt_o,
    output logic             eq_o
);
    logic carry_flag, ovf_flag, lt, gt, eq, ne, hit;

    // Purpose: borrow flag and signed overflow from the top carries.
    always_comb begin
        carry_flag = ~co_top[1];
        ovf_flag   = co_top[1] ^ co_top[0];
    end

    // Purpose: derive the four relations from the shared subtraction.
    always_comb begin
        lt = signed_mode ? (ovf_flag ^ y_msb) : carry_flag;
        eq = &x;
        ne = ~eq;
        gt = ~(lt | eq);
    end

    // Purpose: OR the selected relations and zero-extend the result.
    always_comb begin
        hit     = |({ne, eq, gt, lt} & sel);
        cmp_out = CMP_W'(hit);
        lt_o    = lt;
        eq_o    = eq;
    end

    // Purpose: a subtraction yields exactly one ordering relation.
    always_comb begin
        if (sub_mode) begin
            AST_ONE_RELATION: assert ($countones({lt, gt, eq}) == 1)
                else $error("relations not exclusive"); // R8
        end
    end
endmodule

// File: rtl/shared_sub_alu.sv
// Module: top of the shared-subtractor ALU. Widens both operands,
// runs one carry chain and decodes the comparisons from it.
// Assumes: Y_W >= A_W, Y_W >= B_W, Y_W >= 2, CMP_W >= 1.
module shared_sub_alu
    import alu_pkg::*;
#(
    parameter int A_W   = 8,
    parameter int B_W   = 8,
    parameter int Y_W   = 8,
    parameter int CMP_W = 1
) (
    input  logic [A_W-1:0]       a,
    input  logic [B_W-1:0]       b,
    input  logic                 ci,
    input  logic                 bi,
    input  logic                 signed_mode,
    input  logic [REL_SEL_W-1:0] cmp_sel,
    output logic [Y_W-1:0]       y,
    output logic [Y_W-1:0]       x,
    output logic [Y_W-1:0]       co,
    output logic [CMP_W-1:0]     cmp_out
);
    localparam int W = Y_W;

    logic [W-1:0] a_ext, b_ext;
    logic         a_neg, b_neg;
    logic         sub_mode, lt_w, eq_w, lt_ref;

    // Purpose: comparisons are defined only for A + ~B + 1.
    always_comb sub_mode = bi & ci;

    opnd_extend #(.IN_W(A_W), .OUT_W(W)) u_ext_a (
        .opnd(a), .signed_mode(signed_mode), .opnd_ext(a_ext), .opnd_neg(a_neg)
    );

    opnd_extend #(.IN_W(B_W), .OUT_W(W)) u_ext_b (
        .opnd(b), .signed_mode(signed_mode), .opnd_ext(b_ext), .opnd_neg(b_neg)
    );

    ripple_addsub #(.W(W)) u_chain (
        .a(a_ext), .b(b_ext), .ci(ci), .bi(bi), .y(y), .x(x), .co(co)
    );

    rel_decode #(.W(W), .CMP_W(CMP_W)) u_rel (
        .x(x), .co_top(co[W-1:W-2]), .y_msb(y[W-1]),
        .signed_mode(signed_mode), .sub_mode(sub_mode),
        .sel(rel_sel_t'(cmp_sel)), .cmp_out(cmp_out),
        .lt_o(lt_w), .eq_o(eq_w)
    );

    // Purpose: independent ordering from operand signs and magnitudes.
    always_comb lt_ref = (a_neg != b_neg) ? a_neg : (a_ext < b_ext);

    // Purpose: carry-derived relations match a direct comparison.
    always_comb begin
        if (sub_mode) begin
            AST_LT_MATCH: assert (lt_w == lt_ref)
                else $error("less-than mismatch"); // R5 R6
            AST_EQ_ZERO_DIFF: assert (eq_w == (y == '0))
                else $error("equal vs zero difference"); // R7
        end
    end
endmodule

// File: tb/shared_sub_alu_test.sv
// Bench: exhaustive sweep of a small configuration (A_W=4, B_W=3,
// Y_W=4, CMP_W=2) with expected values computed arithmetically.
module shared_sub_alu_test;
    localparam int AW = 4;
    localparam int BW = 3;
    localparam int YW = 4;
    localparam int CW = 2;
    localparam int MASK = (1 << YW) - 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [AW-1:0] a = '0;
    logic [BW-1:0] b = '0;
    logic ci = 1'b0, bi = 1'b0, signed_mode = 1'b0;
    logic [3:0] cmp_sel = '0;
    logic [YW-1:0] y, x, co;
    logic [CW-1:0] cmp_out;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    shared_sub_alu #(.A_W(AW), .B_W(BW), .Y_W(YW), .CMP_W(CW)) uut (
        .a(a), .b(b), .ci(ci), .bi(bi), .signed_mode(signed_mode),
        .cmp_sel(cmp_sel), .y(y), .x(x), .co(co), .cmp_out(cmp_out)
    );

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000 && !done) begin
            failures = failures + 1;
            $display("FAIL watchdog: actual=%0d expected<150000 cycles", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    function automatic int ext_val(int v, int w, bit s);
        if (s && v[w-1]) return v - (1 << w);
        return v;
    endfunction

    task automatic check(string req, int act, int exp);
        checks = checks + 1;
        if (act != exp) begin
            failures = failures + 1;
            $display("FAIL %s: actual=%0d expected=%0d (a=%0d b=%0d s=%0b bi=%0b ci=%0b sel=%b)",
                     req, act, exp, a, b, signed_mode, bi, ci, cmp_sel);
        end
    endtask

    // Drive on the rising edge, sample on the falling edge.
    task automatic apply(int av, int bv, bit s, bit inv, bit cin, int sel);
        @(posedge clk);
        a = AW'(av); b = BW'(bv); signed_mode = s; bi = inv; ci = cin;
        cmp_sel = 4'(sel);
        @(negedge clk);
    endtask

    initial begin
        repeat (2) @(posedge clk);
        rst_n = 1'b1;
        // Idle state: all inputs zero.
        apply(0, 0, 1'b0, 1'b0, 1'b0, 0);
        check("R1 idle y", int'(y), 0);
        check("R9 idle cmp", int'(cmp_out), 0);

        for (int s = 0; s < 2; s++) begin
            for (int inv = 0; inv < 2; inv++) begin
                for (int cin = 0; cin < 2; cin++) begin
                    for (int av = 0; av < (1 << AW); av++) begin
                        for (int bv = 0; bv < (1 << BW); bv++) begin
                            int ea, eb, abits, bbits, beff, exp_y, exp_x, exp_co, m;
                            bit lt, gt, eq, ne;
                            ea = ext_val(av, AW, bit'(s));
                            eb = ext_val(bv, BW, bit'(s));
                            abits = ea & MASK;   // R4: widened pattern
                            bbits = eb & MASK;
                            beff = inv ? (~bbits & MASK) : bbits;
                            exp_y = (abits + beff + cin) & MASK;
                            exp_x = abits ^ beff;
                            exp_co = 0;
                            for (int i = 0; i < YW; i++) begin
                                m = (1 << (i + 1)) - 1;
                                if ((((abits & m) + (beff & m) + cin) >> (i + 1)) & 1)
                                    exp_co = exp_co | (1 << i);
                            end
                            apply(av, bv, bit'(s), bit'(inv), bit'(cin), 0);
                            check("R1 R4 sum", int'(y), exp_y);
                            check("R2 propagate", int'(x), exp_x);
                            check("R3 carries", int'(co), exp_co);
                            if (inv == 1 && cin == 1) begin
                                lt = (ea < eb);
                                eq = (ea == eb);
                                gt = (ea > eb);
                                ne = !eq;
                                for (int sel = 0; sel < 16; sel++) begin
                                    int exp_c;
                                    exp_c = ((sel[0] & lt) | (sel[1] & gt) |
                                             (sel[2] & eq) | (sel[3] & ne)) ? 1 : 0;
                                    apply(av, bv, bit'(s), 1'b1, 1'b1, sel);
                                    if (sel == 1)
                                        check(s ? "R6 signed lt" : "R5 unsigned lt",
                                              int'(cmp_out), exp_c);
                                    else if (sel == 4 || sel == 8)
                                        check("R7 eq/ne", int'(cmp_out), exp_c);
                                    else if (sel == 2)
                                        check("R8 gt", int'(cmp_out), exp_c);
                                    else
                                        check("R9 combined select", int'(cmp_out), exp_c);
                                end
                            end
                        end
                    end
                end
            end
        end

        // Corner: most-negative A against all-ones B, signed, less-or-equal.
        apply(8, 7, 1'b1, 1'b1, 1'b1, 5);
        check("R6 R9 most-negative le", int'(cmp_out), 1);
        apply(15, 7, 1'b0, 1'b1, 1'b1, 6);
        check("R5 R9 all-ones ge", int'(cmp_out), 1);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule